// File: doc/BRIEF.md
# Triangle-Carrier PWM Phase Leg with Asymmetric Dead Time

This block drives one half-bridge leg of an inverter. An up/down counter sweeps a symmetric triangle between zero and a programmable peak. The count is compared with a duty value to form an ideal drive, and a complementary pair of outputs is derived from that drive. A single down-counting dead-time sub-counter sits between the ideal drive and the pins. It holds off the positive-phase output for one programmable interval after the drive rises. It holds off the negative-phase output for a separate interval after the drive falls, so the two switching edges can get different guard times. If the drive is high or low for less than the matching guard time, that output's pulse is dropped completely.

Duty writes go into a holding register and are applied only at the triangle valley, so the shape of the waveform never changes partway through a period. Each pin has a level-inversion bit. While the count enable is low, both pins sit at their inactive level and the counter waits at 0xFFFE, two steps below zero. The block pulses one flag at every valley and another each time a dead-time interval expires.

Top module: `tri_pwm_dt`

## Requirements
- R1: While `cnt_en` is high, `tri_cnt` advances by one step per clock from 0xFFFE through 0xFFFF and 0 up to `cycle_val`, then down to 0, then up again. In steady state the period is 2*`cycle_val` clocks.
- R2: `cnt_uf` is high for exactly one clock in each cycle where `tri_cnt` is 0, which gives one pulse per period. It is never high at any other count.
- R3: With duty D below `cycle_val`, the ideal drive is high for 2D-1 consecutive clocks centred on the valley. The positive phase is active for (2D-1) - `dt_pos` clocks per period. It is not active at all when 2D-1 is not larger than `dt_pos`.
- R4: The negative phase is active for (2*`cycle_val` - 2D + 1) - `dt_neg` clocks per period, and not at all when that low interval is not larger than `dt_neg`. With D = 0 it is active for the whole period.
- R5: The two phases are never active in the same clock. Per period, the clocks in which neither phase is active total `dt_pos` + `dt_neg` whenever both pulses survive.
- R6: With D at or above `cycle_val`, the positive phase is active for every clock of the period and the negative phase never becomes active.
- R7: A value written with `duty_wr` has no effect on the outputs until `tri_cnt` next reaches 0. From that valley on, the new value governs.
- R8: `inv_pos` and `inv_neg` each invert their pin, so a pin reads 1 when its phase is inactive.
- R9: While `cnt_en` is low, each pin shows its inactive level (equal to its inversion bit), `tri_cnt` is 0xFFFE after the next clock, and both flags are 0.
- R10: `sub_uf` pulses for one clock each time a non-zero dead-time countdown reaches zero. A countdown that is cut short by a new drive edge produces no pulse.
- R11: A dead time of zero lets the matching phase switch in the same clock as the ideal drive, with no gap on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable; low stops and clears the counters |
| cycle_val | input | W | Triangle peak count |
| duty_wr | input | 1 | Loads `duty_in` into the holding register |
| duty_in | input | W | New duty compare value |
| dt_pos | input | W | Guard time before the positive phase turns on |
| dt_neg | input | W | Guard time before the negative phase turns on |
| inv_pos | input | 1 | Inverts the positive-phase pin |
| inv_neg | input | 1 | Inverts the negative-phase pin |
| tri_cnt | output | W | Current triangle count |
| cnt_uf | output | 1 | Valley flag, high while the count is 0 |
| sub_uf | output | 1 | Dead-time expiry flag |
| pwm_pos | output | 1 | Positive-phase pin |
| pwm_neg | output | 1 | Negative-phase pin |

## Verification
The hardest case to reach is a drive pulse shorter than the guard time, where the sub-counter is reloaded before it reaches zero. In that case an output pulse and its expiry flag must both be missing. The stimulus reaches it with duties of 1 and one below the peak, which make high and low windows one to three clocks wide against guard times of 2 and 4. It then counts active clocks and `sub_uf` pulses over whole valley-to-valley windows. The deferred duty load is tested by writing a full-scale duty in the middle of a rising slope and confirming that the positive pin stays off until the valley flag.

// File: rtl/tri_pwm_dt.sv
module tri_pwm_dt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [W-1:0] cycle_val,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_in,
  input  logic [W-1:0] dt_pos,
  input  logic [W-1:0] dt_neg,
  input  logic         inv_pos,
  input  logic         inv_neg,
  output logic [W-1:0] tri_cnt,
  output logic         cnt_uf,
  output logic         sub_uf,
  output logic         pwm_pos,
  output logic         pwm_neg
);
  localparam logic [W-1:0] START = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_nx, duty_buf, duty_act, sub_q;
  logic up_q, up_nx, started_q, raw_q, raw_nx, uf_q, suf_q, valley;

  always_comb begin
    if (up_q) begin
      up_nx  = (cnt_q != cycle_val);
      cnt_nx = (cnt_q == cycle_val) ? cycle_val - ONE : cnt_q + ONE;
    end else begin
      up_nx  = (cnt_q == '0);
      cnt_nx = (cnt_q == '0) ? ONE : cnt_q - ONE;
    end
  end

  assign valley = (cnt_nx == '0);
  assign raw_nx = started_q && ((duty_act >= cycle_val) || (cnt_q < duty_act));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       duty_buf <= '0;
    else if (duty_wr) duty_buf <= duty_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= START;
      up_q      <= 1'b1;
      started_q <= 1'b0;
      duty_act  <= '0;
      raw_q     <= 1'b0;
      sub_q     <= '0;
      uf_q      <= 1'b0;
      suf_q     <= 1'b0;
    end else if (!cnt_en) begin
      cnt_q     <= START;
      up_q      <= 1'b1;
      started_q <= 1'b0;
      raw_q     <= 1'b0;
      sub_q     <= '0;
      uf_q      <= 1'b0;
      suf_q     <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      up_q  <= up_nx;
      uf_q  <= valley;
      if (valley) begin
        started_q <= 1'b1;
        duty_act  <= duty_buf;
      end
      raw_q <= raw_nx;
      suf_q <= (raw_nx == raw_q) && (sub_q == ONE);
      if (raw_nx != raw_q)  sub_q <= raw_nx ? dt_pos : dt_neg;
      else if (sub_q != '0) sub_q <= sub_q - ONE;
    end
  end

  assign tri_cnt = cnt_q;
  assign cnt_uf  = uf_q;
  assign sub_uf  = suf_q;
  assign pwm_pos = (cnt_en && raw_q && (sub_q == '0)) ^ inv_pos;
  assign pwm_neg = (cnt_en && !raw_q && (sub_q == '0)) ^ inv_neg;
endmodule

// File: rtl/tri_pwm_dt_chk.sv
module tri_pwm_dt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         inv_pos,
  input logic         inv_neg,
  input logic [W-1:0] tri_cnt,
  input logic         cnt_uf,
  input logic         sub_uf,
  input logic         pwm_pos,
  input logic         pwm_neg
);
  localparam logic [W-1:0] START = {{(W-1){1'b1}}, 1'b0};

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !((pwm_pos ^ inv_pos) && (pwm_neg ^ inv_neg))); // R5

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> ((tri_cnt == W'($past(tri_cnt) + 1'b1)) ||
                (tri_cnt == W'($past(tri_cnt) - 1'b1)))); // R1

  AST_UF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_uf |-> (tri_cnt == '0)); // R2

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> (pwm_pos == inv_pos) && (pwm_neg == inv_neg)); // R9

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (tri_cnt == START) && !cnt_uf && !sub_uf); // R9
endmodule

bind tri_pwm_dt tri_pwm_dt_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .inv_pos(inv_pos),
  .inv_neg(inv_neg), .tri_cnt(tri_cnt), .cnt_uf(cnt_uf), .sub_uf(sub_uf),
  .pwm_pos(pwm_pos), .pwm_neg(pwm_neg)
);

// File: tb/tri_pwm_dt_tb_top.sv
module tri_pwm_dt_tb_top;
  localparam int W = 16;
  localparam int C = 16;

  logic clk = 0, rst_n = 0, cnt_en = 0, duty_wr = 0, inv_pos = 0, inv_neg = 0;
  logic [W-1:0] cycle_val = W'(C), duty_in = '0, dt_pos = '0, dt_neg = '0;
  logic [W-1:0] tri_cnt;
  logic cnt_uf, sub_uf, pwm_pos, pwm_neg;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  tri_pwm_dt #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cycle_val(cycle_val),
    .duty_wr(duty_wr), .duty_in(duty_in), .dt_pos(dt_pos), .dt_neg(dt_neg),
    .inv_pos(inv_pos), .inv_neg(inv_neg), .tri_cnt(tri_cnt), .cnt_uf(cnt_uf),
    .sub_uf(sub_uf), .pwm_pos(pwm_pos), .pwm_neg(pwm_neg)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_uf();
    int n = 0;
    while (!cnt_uf && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(output int ph, output int nh, output int gap,
                         output int su, output int uf);
    ph = 0; nh = 0; gap = 0; su = 0; uf = 0;
    for (int i = 0; i < 2 * C; i++) begin
      if (pwm_pos) ph++;
      if (pwm_neg) nh++;
      if (!(pwm_pos ^ inv_pos) && !(pwm_neg ^ inv_neg)) gap++;
      if (sub_uf) su++;
      if (cnt_uf) uf++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int d, input int dp, input int dn, input logic ip, input logic in);
    @(negedge clk);
    cnt_en = 0; inv_pos = ip; inv_neg = in;
    dt_pos = W'(dp); dt_neg = W'(dn); duty_in = W'(d); duty_wr = 1;
    @(negedge clk);
    duty_wr = 0; cnt_en = 1;
    @(negedge clk);
    wait_uf(); @(negedge clk);
    wait_uf(); @(negedge clk);
    wait_uf();
  endtask

  task automatic t_reset();
    chk("R9 idle count", int'(tri_cnt), 'hFFFE);
    chk("R9 idle pos pin", int'(pwm_pos), 0);
    chk("R9 idle neg pin", int'(pwm_neg), 0);
    chk("R9 idle flag", int'(cnt_uf), 0);
  endtask

  task automatic t_start();
    @(negedge clk); cnt_en = 0;
    @(negedge clk);
    chk("R1 held at start", int'(tri_cnt), 'hFFFE);
    cnt_en = 1;
    @(negedge clk);
    chk("R1 first step", int'(tri_cnt), 'hFFFF);
    @(negedge clk);
    chk("R1 reach zero", int'(tri_cnt), 0);
    chk("R2 flag at first zero", int'(cnt_uf), 1);
    repeat (C) @(negedge clk);
    chk("R1 peak", int'(tri_cnt), C);
    chk("R2 no flag at peak", int'(cnt_uf), 0);
    repeat (C) @(negedge clk);
    chk("R1 back to valley", int'(tri_cnt), 0);
    chk("R2 flag at valley", int'(cnt_uf), 1);
  endtask

  task automatic t_duty(input string req, input int d, input int dp, input int dn,
                        input int eph, input int enh, input int egap, input int esu);
    int ph, nh, gap, su, uf;
    setup(d, dp, dn, 0, 0);
    measure(ph, nh, gap, su, uf);
    chk({req, " pos clocks"}, ph, eph);
    chk({req, " neg clocks"}, nh, enh);
    if (egap >= 0) chk({req, " R5 guard clocks"}, gap, egap);
    chk({req, " R10 expiry pulses"}, su, esu);
    chk({req, " R2 valley pulses"}, uf, 1);
  endtask

  task automatic t_reload();
    int n = 0, hits = 0;
    int ph, nh, gap, su, uf;
    setup(0, 2, 4, 0, 0);
    repeat (5) @(negedge clk);
    duty_in = W'(C); duty_wr = 1;
    @(negedge clk);
    duty_wr = 0;
    while (!cnt_uf && n < 1000) begin
      if (pwm_pos) hits++;
      @(negedge clk);
      n++;
    end
    if (pwm_pos) hits++;
    chk("R7 no effect before valley", hits, 0);
    @(negedge clk);
    wait_uf();
    measure(ph, nh, gap, su, uf);
    chk("R7 new duty after valley pos", ph, 2 * C);
    chk("R7 new duty after valley neg", nh, 0);
  endtask

  task automatic t_invert();
    int ph, nh, gap, su, uf;
    setup(8, 2, 4, 1, 1);
    measure(ph, nh, gap, su, uf);
    chk("R8 inverted pos pin high", ph, 2 * C - 13);
    chk("R8 inverted neg pin high", nh, 2 * C - 13);
    chk("R8 R5 guard under inversion", gap, 6);
    cnt_en = 0;
    @(negedge clk);
    chk("R8 R9 idle pos pin inverted", int'(pwm_pos), 1);
    chk("R8 R9 idle neg pin inverted", int'(pwm_neg), 1);
  endtask

  task automatic t_disable();
    setup(8, 2, 4, 0, 0);
    repeat (7) @(negedge clk);
    cnt_en = 0;
    @(negedge clk);
    chk("R9 stop count", int'(tri_cnt), 'hFFFE);
    chk("R9 stop pos", int'(pwm_pos), 0);
    chk("R9 stop neg", int'(pwm_neg), 0);
    chk("R9 stop valley flag", int'(cnt_uf), 0);
    chk("R9 stop expiry flag", int'(sub_uf), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start();
    t_duty("R3 R4 nominal", 8, 2, 4, 13, 13, 6, 2);
    t_duty("R3 R10 narrow high dropped", 1, 2, 4, 0, 27, -1, 1);
    t_duty("R3 just above guard", 2, 2, 4, 1, 25, 6, 2);
    t_duty("R4 zero duty", 0, 2, 4, 0, 2 * C, -1, 0);
    t_duty("R4 R10 narrow low dropped", 15, 2, 4, 27, 0, -1, 1);
    t_duty("R6 duty at peak", C, 2, 4, 2 * C, 0, -1, 0);
    t_duty("R6 duty above peak", C + 4, 2, 4, 2 * C, 0, -1, 0);
    t_duty("R11 zero guard asym", 8, 0, 6, 15, 11, 6, 1);
    t_reload();
    t_invert();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule